// File: doc/BRIEF.md
# Wake-up Fault Blanking Controller

This block paces a driver's host operations around the quiet periods that follow a configuration write, a wake-up and the clearing of a fault. A configuration write makes the block count a short settle period, and `cfg_settled` goes low for that time. A write that clears the sleep bit also opens a fault-blanking window. A status read that reports a cleared fault opens a fault-blanking window of its own. While any window is open, `blank_active` is high and the block turns away host requests that must not run yet.

Two host requests are judged: a data-buffer write and a start-transmission command. Each arrives as a one-cycle strobe. There is no back-pressure: every strobe gets exactly one answer, an accept pulse or a reject pulse, one cycle later. The host must treat a reject as final and issue the request again once the window has closed. The decision uses the state as it stood before the clock edge that samples the request, so a configuration write in the same cycle does not affect that request. Decoding of the serial command and detection of faults happen outside this block.

Top module: `wake_blank_ctrl`

## Requirements
- R1: After every configuration write, `cfg_settled` is low for exactly 4 cycles, starting with the cycle after the write, and then returns high. A new write restarts the count.
- R2: A configuration write with `cfg_sleep`=0 (wake) holds `blank_active` high for 128 cycles, starting with the cycle after the write. This is the 4 settle cycles followed by 124 blanking cycles.
- R3: A configuration write with `cfg_sleep`=1 opens no window and leaves any wake window already running unchanged.
- R4: A status read with `sts_fault_clr`=1 holds `blank_active` high for 128 cycles, starting with the cycle after the read. A read with `sts_fault_clr`=0 has no effect.
- R5: A wake write or a fault-clearing read that arrives while its own window is open restarts that window's count from the full length.
- R6: When both windows are open, `blank_active` stays high until the later of the two expires.
- R7: A buffer-write request is rejected while blanking is active and the autosend bit is 1. In every other case it is accepted. The autosend bit is the value of `cfg_autosend` from the latest configuration write, and it is 0 after reset.
- R8: A start request is rejected whenever blanking is active and accepted otherwise.
- R9: Each request gets exactly one one-cycle pulse, ack or reject, in the cycle after the request. With no request there is no pulse. The decision uses the state before the sampling edge.
- R10: Reset clears all counters and the autosend bit, so `blank_active` is low, `cfg_settled` is high and no pulses are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sleep | input | 1 | Sleep bit of the written configuration (0 = wake) |
| cfg_autosend | input | 1 | Autosend bit of the written configuration |
| sts_rd | input | 1 | Status read strobe |
| sts_fault_clr | input | 1 | The status read cleared a fault |
| buf_wr_req | input | 1 | Data-buffer write request strobe |
| start_req | input | 1 | Start-transmission request strobe |
| buf_wr_ack | output | 1 | Buffer write accepted (one-cycle pulse) |
| buf_wr_rej | output | 1 | Buffer write rejected (one-cycle pulse) |
| start_ack | output | 1 | Start accepted (one-cycle pulse) |
| start_rej | output | 1 | Start rejected (one-cycle pulse) |
| blank_active | output | 1 | A fault-blanking window is open |
| cfg_settled | output | 1 | The settle period after the last configuration write is over |

## Verification
The bench issues requests on the last blanked cycle and on the first free cycle of a window. A design with an off-by-one window length would accept or reject one of those requests wrongly. It repeats wake writes and fault-clearing reads while their windows are open, and it opens the two windows in both orders. A design that ignored a restart or dropped the longer window would close blanking early. A sleep write is sent during a wake window, along with a status read that cleared nothing, to catch a design that cancels or opens windows on those events. A wake write is also sent in the same cycle as a start request, which catches a design that decides a request on the state after the edge instead of the state before it.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  // request channels judged by the gate array
  typedef enum logic {
    CH_BUF   = 1'b0,
    CH_START = 1'b1
  } wbc_chan_e;

  localparam int WBC_NCH  = 2;
  // window counters: settle, wake blanking, fault blanking
  localparam int WBC_NWIN = 3;
  localparam int WIN_SETTLE = 0;
  localparam int WIN_WAKE   = 1;
  localparam int WIN_FAULT  = 2;
endpackage

// File: rtl/wbc_window_cnt.sv
module wbc_window_cnt #(
  parameter int W   = 8,
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= W'(LEN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R5
  load_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R3
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !busy) |=> !busy);
endmodule

// File: rtl/wbc_req_gate.sv
module wbc_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic block,
  output logic ack,
  output logic rej
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rej <= 1'b0;
    end else begin
      ack <= req && !block;
      rej <= req && block;
    end
  end

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (ack != rej));

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!ack && !rej));
endmodule

// File: rtl/wake_blank_ctrl.sv
module wake_blank_ctrl #(
  parameter int SETTLE_CYCLES      = 4,
  parameter int WAKE_BLANK_CYCLES  = 124,
  parameter int FAULT_BLANK_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_sleep,
  input  logic cfg_autosend,
  input  logic sts_rd,
  input  logic sts_fault_clr,
  input  logic buf_wr_req,
  input  logic start_req,
  output logic buf_wr_ack,
  output logic buf_wr_rej,
  output logic start_ack,
  output logic start_rej,
  output logic blank_active,
  output logic cfg_settled
);
  import wbc_pkg::*;

  localparam int WAKE_LEN = SETTLE_CYCLES + WAKE_BLANK_CYCLES;
  localparam int MAX_LEN  = (WAKE_LEN > FAULT_BLANK_CYCLES) ? WAKE_LEN : FAULT_BLANK_CYCLES;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic [WBC_NWIN-1:0] win_load;
  logic [WBC_NWIN-1:0] win_busy;
  logic                autosend_q;

  assign win_load[WIN_SETTLE] = cfg_wr;
  assign win_load[WIN_WAKE]   = cfg_wr && !cfg_sleep;
  assign win_load[WIN_FAULT]  = sts_rd && sts_fault_clr;

  genvar g;
  generate
    for (g = 0; g < WBC_NWIN; g++) begin : g_win
      localparam int LEN = (g == WIN_SETTLE) ? SETTLE_CYCLES :
                           (g == WIN_WAKE)   ? WAKE_LEN : FAULT_BLANK_CYCLES;
      wbc_window_cnt #(.W(CNT_W), .LEN(LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load[g]),
        .busy  (win_busy[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      autosend_q <= 1'b0;
    else if (cfg_wr) autosend_q <= cfg_autosend;
  end

  assign blank_active = win_busy[WIN_WAKE] || win_busy[WIN_FAULT];
  assign cfg_settled  = !win_busy[WIN_SETTLE];

  logic [WBC_NCH-1:0] ch_req, ch_block, ch_ack, ch_rej;

  assign ch_req[CH_BUF]     = buf_wr_req;
  assign ch_req[CH_START]   = start_req;
  assign ch_block[CH_BUF]   = blank_active && autosend_q;
  assign ch_block[CH_START] = blank_active;

  generate
    for (g = 0; g < WBC_NCH; g++) begin : g_gate
      wbc_req_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ch_req[g]),
        .block (ch_block[g]),
        .ack   (ch_ack[g]),
        .rej   (ch_rej[g])
      );
    end
  endgenerate

  assign buf_wr_ack = ch_ack[CH_BUF];
  assign buf_wr_rej = ch_rej[CH_BUF];
  assign start_ack  = ch_ack[CH_START];
  assign start_rej  = ch_rej[CH_START];

  // R1
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_settled);

  // R2
  wake_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sleep) |=> blank_active);

  // R4
  fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && sts_fault_clr) |=> blank_active);

  // R8
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |-> !$past(blank_active));

  // R7
  buf_rej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_rej |-> $past(blank_active));
endmodule

// File: tb/wake_blank_ctrl_test.sv
`timescale 1ns/1ps
module wake_blank_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sleep = 0, cfg_autosend = 0;
  logic sts_rd = 0, sts_fault_clr = 0;
  logic buf_wr_req = 0, start_req = 0;
  logic buf_wr_ack, buf_wr_rej, start_ack, start_rej, blank_active, cfg_settled;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wake_blank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sleep(cfg_sleep),
    .cfg_autosend(cfg_autosend), .sts_rd(sts_rd), .sts_fault_clr(sts_fault_clr),
    .buf_wr_req(buf_wr_req), .start_req(start_req),
    .buf_wr_ack(buf_wr_ack), .buf_wr_rej(buf_wr_rej),
    .start_ack(start_ack), .start_rej(start_rej),
    .blank_active(blank_active), .cfg_settled(cfg_settled)
  );

  // expected model, built from the requirements
  int m_settle = 0, m_wake = 0, m_fault = 0;
  bit m_auto = 0;
  bit buf_q[$];
  bit st_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_settle = 0; m_wake = 0; m_fault = 0; m_auto = 0;
      buf_q.delete(); st_q.delete();
    end else begin
      bit pre_blank;
      pre_blank = (m_wake != 0) || (m_fault != 0);
      if (buf_wr_req) buf_q.push_back(!(pre_blank && m_auto));   // R7
      if (start_req)  st_q.push_back(!pre_blank);                // R8
      if (cfg_wr) m_settle = 4; else if (m_settle != 0) m_settle--;          // R1
      if (cfg_wr && !cfg_sleep) m_wake = 128; else if (m_wake != 0) m_wake--; // R2 R3 R5
      if (sts_rd && sts_fault_clr) m_fault = 128; else if (m_fault != 0) m_fault--; // R4 R5
      if (cfg_wr) m_auto = cfg_autosend;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares every cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        bit e;
        check("R2 R3 R4 R5 R6 blank_active", blank_active, (m_wake != 0) || (m_fault != 0));
        check("R1 cfg_settled", cfg_settled, m_settle == 0);
        if (buf_q.size() > 0) begin
          e = buf_q.pop_front();
          check("R7 R9 buf_wr_ack", buf_wr_ack, e);
          check("R7 R9 buf_wr_rej", buf_wr_rej, !e);
        end else begin
          check("R9 buf idle", {buf_wr_ack, buf_wr_rej}, 0);
        end
        if (st_q.size() > 0) begin
          e = st_q.pop_front();
          check("R8 R9 start_ack", start_ack, e);
          check("R8 R9 start_rej", start_rej, !e);
        end else begin
          check("R9 start idle", {start_ack, start_rej}, 0);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit slp, input bit aut);
    cfg_wr = 1; cfg_sleep = slp; cfg_autosend = aut;
    tick(1);
    cfg_wr = 0;
  endtask

  task automatic rd(input bit clr);
    sts_rd = 1; sts_fault_clr = clr;
    tick(1);
    sts_rd = 0; sts_fault_clr = 0;
  endtask

  task automatic req(input bit b, input bit s);
    buf_wr_req = b; start_req = s;
    tick(1);
    buf_wr_req = 0; start_req = 0;
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R10 reset state
    check("R10 blank after reset", blank_active, 0);
    check("R10 settled after reset", cfg_settled, 1);
    check("R10 pulses after reset", {buf_wr_ack, buf_wr_rej, start_ack, start_rej}, 0);
    tick(2);
    req(1, 1);                       // R9 accepted when idle
    tick(2);
    cfg(1, 1);                       // R3 sleep write: settle only
    req(1, 1);
    tick(6);
    // R9 wake write in same cycle as start: decided on old state
    cfg_wr = 1; cfg_sleep = 0; cfg_autosend = 1; start_req = 1;
    tick(1);
    cfg_wr = 0; start_req = 0;
    tick(2);
    req(1, 1);                       // R7 R8 both rejected
    tick(60);
    cfg(0, 1);                       // R5 restart wake window
    tick(120);
    for (int i = 0; i < 12; i++) req(0, 1);   // R2 edge of window
    tick(10);
    cfg(0, 0);                       // R7 autosend off
    tick(5);
    req(1, 1);
    tick(20);
    cfg(1, 0);                       // R3 sleep write mid window
    req(1, 1);
    tick(140);
    rd(0);                           // R4 no clear: nothing
    tick(3);
    req(1, 1);
    rd(1);                           // R4 fault window
    tick(50);
    rd(1);                           // R5 restart fault window
    tick(30);
    cfg(0, 1);                       // R6 wake outlasts fault
    tick(110);
    for (int i = 0; i < 30; i++) req(1, 1);
    tick(40);
    cfg(0, 1);
    tick(100);
    rd(1);                           // R6 fault outlasts wake
    tick(100);
    for (int i = 0; i < 40; i++) req(1, 1);
    tick(20);
    check("R9 queues drained", buf_q.size() + st_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule